// File: doc/BRIEF.md
# Serial Flash Command Front-End

This block sits behind the four SPI pins of a serial NOR flash. It turns the bit stream on `si` into whole bytes, decodes the leading byte as an opcode and collects any address, dummy and data bytes that follow. It produces the bytes that are shifted out on `so`. Reads fetch bytes from a synchronous, byte-wide array port, one byte ahead of the shifter. Status reads present a live status byte supplied by the back-end. Identification reads return fixed ID bytes that are set by parameters.

Commands that change state are turned into single-cycle requests on a back-end port. Each request carries a kind code, a 24-bit address and a data byte. Page-program bytes are forwarded as they arrive. Every other modifying command is released when chip select goes high, and only if the frame held the right number of whole bytes. The block also tracks deep power-down. In that state it ignores every opcode except the wake-up opcode.

All pins are sampled on the system clock `clk`, and SCLK edges are found by comparing each sample with the previous one. The back-end therefore sees a single clock domain.

Top module: `spi_flash_fe`

## Requirements
- R1: SI is taken on a rising SCLK edge and SO moves only after a falling edge. `soEn` is 0 while `csN` is high and before the first output byte of a frame starts.
- R2: Opcode 05h shifts out the `statusIn` byte again and again until CS rises. The value used is the one captured at the end of the previous byte.
- R3: Opcode 9Fh shifts out MFR_ID, then DEV_ID_HI, then DEV_ID_LO, and repeats that group of three.
- R4: Opcode 90h is followed by two ignored bytes and then a select byte. If bit 0 of the select byte is 0, output starts with MFR_ID and alternates with ELEC_ID. If bit 0 is 1, output starts with ELEC_ID and alternates.
- R5: Opcode 03h takes three address bytes, most significant byte first. It then streams array bytes from that address upwards. After the last address (2^ADDR_W − 1) it continues from address 0.
- R6: Opcode 0Bh behaves like 03h, except that one dummy byte follows the address before any data is shifted out.
- R7: Opcode 02h takes three address bytes. Each further whole byte raises one request of kind 4, with data equal to that byte. Its address keeps bits 23:8 and its low byte starts at the given value and counts up modulo 256.
- R8: When CS rises after exactly one whole byte, the block raises one request: 06h gives kind 1, 04h gives kind 2, 60h or C7h gives kind 6, and B9h gives kind 7.
- R9: When CS rises after exactly four whole bytes of opcode 20h or D8h, the block raises one request of kind 5 carrying the 24-bit address.
- R10: When CS rises after exactly two whole bytes of opcode 01h, the block raises one request of kind 3 whose data is the second byte.
- R11: A frame whose bit count is not a multiple of eight, or whose byte count does not fit the opcode, raises no request.
- R12: After a kind 7 request the block is in deep power-down. In that state no opcode other than ABh raises a request or drives SO. ABh ends deep power-down.
- R13: Opcode ABh is followed by three ignored bytes, after which ELEC_ID repeats until CS rises.
- R14: The same frames work whether SCLK idles low or idles high while CS is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csN | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock, sampled on clk |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| soEn | output | 1 | Output enable for the SO pad (0 means high impedance) |
| statusIn | input | 8 | Status byte from the back-end |
| memRdEn | output | 1 | Array read strobe |
| memAddr | output | ADDR_W | Array read address |
| memRdData | input | 8 | Array data, valid the cycle after memRdEn |
| reqValid | output | 1 | One-cycle request strobe |
| reqKind | output | 3 | Request kind: 1 WREN, 2 WRDI, 3 status write, 4 program byte, 5 sector erase, 6 chip erase, 7 power down |
| reqAddr | output | 24 | Request address |
| reqData | output | 8 | Request data byte |

## Verification
The assertions rely on three properties of the inputs. `csN`, `sclk` and `si` must be synchronous to `clk`. Each SCLK level must last at least four clk cycles, which leaves room for the array fetch and the transmit load. Chip select must stay high for at least one cycle after it rises. The stimulus drives all pins on the falling edge of `clk`, holds each SCLK half period for five cycles, and keeps CS high for several cycles between frames. The array model answers one cycle after a read strobe and holds its output until the next read.

// File: rtl/spi_fe_pkg.sv
package spi_fe_pkg;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_WRDI = 8'h04;
  localparam logic [7:0] OP_RDID = 8'h9F;
  localparam logic [7:0] OP_RDSR = 8'h05;
  localparam logic [7:0] OP_WRSR = 8'h01;
  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_FAST = 8'h0B;
  localparam logic [7:0] OP_PP   = 8'h02;
  localparam logic [7:0] OP_SE_A = 8'h20;
  localparam logic [7:0] OP_SE_B = 8'hD8;
  localparam logic [7:0] OP_CE_A = 8'h60;
  localparam logic [7:0] OP_CE_B = 8'hC7;
  localparam logic [7:0] OP_DP   = 8'hB9;
  localparam logic [7:0] OP_RES  = 8'hAB;
  localparam logic [7:0] OP_REMS = 8'h90;
  localparam logic [7:0] OP_NONE = 8'h00;

  typedef enum logic [2:0] {
    REQ_NONE = 3'd0, REQ_WREN = 3'd1, REQ_WRDI = 3'd2, REQ_WRSR = 3'd3,
    REQ_PROG = 3'd4, REQ_SECT = 3'd5, REQ_CHIP = 3'd6, REQ_DPD = 3'd7
  } reqKind_e;

  typedef struct packed {
    logic       loadTx;
    logic [7:0] txByte;
    logic       outOn;
  } txStrobe_t;
endpackage

// File: rtl/spi_fe_datapath.sv
module spi_fe_datapath
  import spi_fe_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      csN,
  input  logic      sclk,
  input  logic      si,
  input  txStrobe_t strobe,
  output logic [7:0] rxByte,
  output logic      byteDone,
  output logic      csRise,
  output logic      frameAligned,
  output logic      so,
  output logic      soEn
);
  logic       sclkQ, csQ, soR, soEnR;
  logic [2:0] bitCnt;
  logic [6:0] shIn;
  logic [7:0] txBuf, outSh;
  logic       riseE, fallE;

  assign riseE        = !csN && sclk && !sclkQ;
  assign fallE        = !csN && !sclk && sclkQ;
  assign rxByte       = {shIn, si};
  assign byteDone     = riseE && (bitCnt == 3'd7);
  assign csRise       = csN && !csQ;
  assign frameAligned = (bitCnt == 3'd0);
  assign so           = soR;
  assign soEn         = soEnR;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclkQ  <= 1'b0;
      csQ    <= 1'b1;
      bitCnt <= '0;
      shIn   <= '0;
      txBuf  <= '0;
      outSh  <= '0;
      soR    <= 1'b0;
      soEnR  <= 1'b0;
    end else begin
      sclkQ <= sclk;
      csQ   <= csN;
      if (strobe.loadTx) txBuf <= strobe.txByte;
      if (csN) begin
        bitCnt <= '0;
        soEnR  <= 1'b0;
      end else begin
        if (riseE) begin
          shIn   <= {shIn[5:0], si};
          bitCnt <= bitCnt + 3'd1;
        end
        if (fallE) begin
          if (bitCnt == 3'd0) begin
            if (strobe.outOn) begin
              soR   <= txBuf[7];
              outSh <= {txBuf[6:0], 1'b0};
              soEnR <= 1'b1;
            end
          end else begin
            soR   <= outSh[7];
            outSh <= {outSh[6:0], 1'b0};
          end
        end
      end
    end
  end

  // R1
  so_float_chk: assert property (@(posedge clk) disable iff (!rstN) csN |=> !soEn);
  // R1
  so_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclk || !sclkQ) |=> $stable(soR));
endmodule

// File: rtl/spi_fe_ctrl.sv
module spi_fe_ctrl
  import spi_fe_pkg::*;
#(
  parameter int         ADDR_W    = 22,
  parameter logic [7:0] MFR_ID    = 8'hE5,
  parameter logic [7:0] DEV_ID_HI = 8'h20,
  parameter logic [7:0] DEV_ID_LO = 8'h16,
  parameter logic [7:0] ELEC_ID   = 8'h15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic [7:0]        rxByte,
  input  logic              byteDone,
  input  logic              csRise,
  input  logic              frameAligned,
  input  logic [7:0]        statusIn,
  input  logic [7:0]        memRdData,
  output txStrobe_t         strobe,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic              reqValid,
  output logic [2:0]        reqKind,
  output logic [23:0]       reqAddr,
  output logic [7:0]        reqData
);
  logic [7:0]        op, pageLow;
  logic [2:0]        byteIdx;
  logic [23:0]       addr, addrNext, addrLoad;
  logic [1:0]        idSel;
  logic              remsSel, dpMode, outMode, rdPend, memRdEnR, reqValidR;
  logic [ADDR_W-1:0] memAddrR;
  reqKind_e          kindR;
  logic [23:0]       reqAddrR;
  logic [7:0]        reqDataR;

  function automatic logic [7:0] idByte(input logic [1:0] s);
    case (s)
      2'd0:    idByte = MFR_ID;
      2'd1:    idByte = DEV_ID_HI;
      default: idByte = DEV_ID_LO;
    endcase
  endfunction

  assign addrNext = addr + 24'd1;
  assign addrLoad = {addr[15:0], rxByte};
  assign memRdEn  = memRdEnR;
  assign memAddr  = memAddrR;
  assign reqValid = reqValidR;
  assign reqKind  = kindR;
  assign reqAddr  = reqAddrR;
  assign reqData  = reqDataR;

  always_comb begin
    strobe.loadTx = 1'b0;
    strobe.txByte = 8'h00;
    strobe.outOn  = outMode;
    if (rdPend) begin
      strobe.loadTx = 1'b1;
      strobe.txByte = memRdData;
    end else if (byteDone) begin
      if (byteIdx == 3'd0) begin
        if (!dpMode && rxByte == OP_RDSR) begin
          strobe.loadTx = 1'b1; strobe.txByte = statusIn;
        end else if (!dpMode && rxByte == OP_RDID) begin
          strobe.loadTx = 1'b1; strobe.txByte = MFR_ID;
        end
      end else begin
        case (op)
          OP_RDSR: begin strobe.loadTx = 1'b1; strobe.txByte = statusIn; end
          OP_RDID: begin strobe.loadTx = 1'b1; strobe.txByte = idByte(idSel); end
          OP_REMS: begin
            if (byteIdx == 3'd3) begin
              strobe.loadTx = 1'b1; strobe.txByte = rxByte[0] ? ELEC_ID : MFR_ID;
            end else if (byteIdx >= 3'd4) begin
              strobe.loadTx = 1'b1; strobe.txByte = remsSel ? MFR_ID : ELEC_ID;
            end
          end
          OP_RES: if (byteIdx >= 3'd3) begin
            strobe.loadTx = 1'b1; strobe.txByte = ELEC_ID;
          end
          default: ;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      op <= OP_NONE; byteIdx <= '0; addr <= '0; idSel <= '0; remsSel <= 1'b0;
      dpMode <= 1'b0; outMode <= 1'b0; rdPend <= 1'b0; memRdEnR <= 1'b0;
      memAddrR <= '0; pageLow <= '0; reqValidR <= 1'b0; kindR <= REQ_NONE;
      reqAddrR <= '0; reqDataR <= '0;
    end else begin
      memRdEnR  <= 1'b0;
      reqValidR <= 1'b0;
      rdPend    <= memRdEnR;
      if (csRise && frameAligned) begin
        reqAddrR <= addr;
        reqDataR <= addr[7:0];
        case (op)
          OP_WREN: if (byteIdx == 3'd1) begin reqValidR <= 1'b1; kindR <= REQ_WREN; end
          OP_WRDI: if (byteIdx == 3'd1) begin reqValidR <= 1'b1; kindR <= REQ_WRDI; end
          OP_CE_A, OP_CE_B:
            if (byteIdx == 3'd1) begin reqValidR <= 1'b1; kindR <= REQ_CHIP; end
          OP_DP: if (byteIdx == 3'd1) begin
            reqValidR <= 1'b1; kindR <= REQ_DPD; dpMode <= 1'b1;
          end
          OP_SE_A, OP_SE_B:
            if (byteIdx == 3'd4) begin reqValidR <= 1'b1; kindR <= REQ_SECT; end
          OP_WRSR: if (byteIdx == 3'd2) begin reqValidR <= 1'b1; kindR <= REQ_WRSR; end
          default: ;
        endcase
      end
      if (csN) begin
        op <= OP_NONE; byteIdx <= '0; outMode <= 1'b0;
      end else if (byteDone) begin
        if (byteIdx != 3'd7) byteIdx <= byteIdx + 3'd1;
        if (byteIdx == 3'd0) begin
          op    <= (dpMode && rxByte != OP_RES) ? OP_NONE : rxByte;
          idSel <= 2'd1;
          if (rxByte == OP_RES) dpMode <= 1'b0;
          if (!dpMode && (rxByte == OP_RDSR || rxByte == OP_RDID)) outMode <= 1'b1;
        end else begin
          if (byteIdx <= 3'd3) addr <= addrLoad;
          case (op)
            OP_READ: begin
              if (byteIdx == 3'd3) begin
                memRdEnR <= 1'b1; memAddrR <= addrLoad[ADDR_W-1:0]; outMode <= 1'b1;
              end else if (byteIdx >= 3'd4) begin
                memRdEnR <= 1'b1; memAddrR <= addrNext[ADDR_W-1:0]; addr <= addrNext;
              end
            end
            OP_FAST: begin
              if (byteIdx == 3'd4) begin
                memRdEnR <= 1'b1; memAddrR <= addr[ADDR_W-1:0]; outMode <= 1'b1;
              end else if (byteIdx >= 3'd5) begin
                memRdEnR <= 1'b1; memAddrR <= addrNext[ADDR_W-1:0]; addr <= addrNext;
              end
            end
            OP_RDID: idSel <= (idSel == 2'd2) ? 2'd0 : idSel + 2'd1;
            OP_REMS: begin
              if (byteIdx == 3'd3) begin remsSel <= rxByte[0]; outMode <= 1'b1; end
              else if (byteIdx >= 3'd4) remsSel <= !remsSel;
            end
            OP_RES: if (byteIdx == 3'd3) outMode <= 1'b1;
            OP_PP: begin
              if (byteIdx == 3'd3) pageLow <= rxByte;
              else if (byteIdx >= 3'd4) begin
                reqValidR <= 1'b1; kindR <= REQ_PROG;
                reqAddrR  <= {addr[23:8], pageLow};
                reqDataR  <= rxByte;
                pageLow   <= pageLow + 8'd1;
              end
            end
            default: ;
          endcase
        end
      end
    end
  end

  // R8
  cmd_at_deselect_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && kindR != REQ_PROG) |-> $past(csN));
  // R12
  dp_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (dpMode && $past(dpMode)) |-> (!memRdEnR && !outMode && !reqValidR));
  // R7
  prog_live_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && kindR == REQ_PROG) |-> !$past(csN));
endmodule

// File: rtl/spi_flash_fe.sv
module spi_flash_fe
  import spi_fe_pkg::*;
#(
  parameter int         ADDR_W    = 22,
  parameter logic [7:0] MFR_ID    = 8'hE5,
  parameter logic [7:0] DEV_ID_HI = 8'h20,
  parameter logic [7:0] DEV_ID_LO = 8'h16,
  parameter logic [7:0] ELEC_ID   = 8'h15
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              si,
  output logic              so,
  output logic              soEn,
  input  logic [7:0]        statusIn,
  output logic              memRdEn,
  output logic [ADDR_W-1:0] memAddr,
  input  logic [7:0]        memRdData,
  output logic              reqValid,
  output logic [2:0]        reqKind,
  output logic [23:0]       reqAddr,
  output logic [7:0]        reqData
);
  txStrobe_t  strobe;
  logic [7:0] rxByte;
  logic       byteDone, csRise, frameAligned;

  spi_fe_datapath dp_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .strobe(strobe),
    .rxByte(rxByte), .byteDone(byteDone), .csRise(csRise),
    .frameAligned(frameAligned), .so(so), .soEn(soEn)
  );

  spi_fe_ctrl #(
    .ADDR_W(ADDR_W), .MFR_ID(MFR_ID), .DEV_ID_HI(DEV_ID_HI),
    .DEV_ID_LO(DEV_ID_LO), .ELEC_ID(ELEC_ID)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .csN(csN), .rxByte(rxByte), .byteDone(byteDone),
    .csRise(csRise), .frameAligned(frameAligned), .statusIn(statusIn),
    .memRdData(memRdData), .strobe(strobe), .memRdEn(memRdEn), .memAddr(memAddr),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr), .reqData(reqData)
  );
endmodule

// File: tb/spi_flash_fe_tb_top.sv
module spi_flash_fe_tb_top;
  localparam int         AW   = 8;
  localparam int         H    = 5;
  localparam logic [7:0] MFR  = 8'hE5;
  localparam logic [7:0] DHI  = 8'h20;
  localparam logic [7:0] DLO  = 8'h16;
  localparam logic [7:0] ELEC = 8'h15;

  logic clk = 1'b0, rstN = 1'b0, csN = 1'b1, sclk = 1'b0, si = 1'b0;
  logic so, soEn, memRdEn, reqValid;
  logic [7:0] statusIn = 8'h00, memRdData = 8'h00, reqData;
  logic [AW-1:0] memAddr;
  logic [2:0] reqKind;
  logic [23:0] reqAddr;
  logic [7:0] mem [0:(1<<AW)-1];

  int nChk = 0, nBad = 0, reqCnt = 0;
  bit done = 0;
  logic [2:0]  logKind [0:63];
  logic [23:0] logAddr [0:63];
  logic [7:0]  logData [0:63];

  always #4 clk = !clk;

  spi_flash_fe #(.ADDR_W(AW), .MFR_ID(MFR), .DEV_ID_HI(DHI), .DEV_ID_LO(DLO),
                 .ELEC_ID(ELEC)) dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .si(si), .so(so), .soEn(soEn),
    .statusIn(statusIn), .memRdEn(memRdEn), .memAddr(memAddr), .memRdData(memRdData),
    .reqValid(reqValid), .reqKind(reqKind), .reqAddr(reqAddr), .reqData(reqData)
  );

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 8'(i) ^ 8'h3C;
  always @(posedge clk) if (memRdEn) memRdData <= mem[memAddr];
  always @(posedge clk) if (rstN && reqValid && reqCnt < 64) begin
    logKind[reqCnt] = reqKind; logAddr[reqCnt] = reqAddr; logData[reqCnt] = reqData;
    reqCnt = reqCnt + 1;
  end

  function automatic logic [7:0] memExp(input int a);
    return 8'(a) ^ 8'h3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xbits(input logic [7:0] tx, input int n, output logic [7:0] rx, output logic en);
    rx = 8'h00; en = 1'b1;
    for (int i = 0; i < n; i++) begin
      sclk = 1'b0; si = tx[7-i];
      waitc(H);
      rx = {rx[6:0], so}; en = en & soEn;
      sclk = 1'b1;
      waitc(H);
    end
  endtask

  task automatic xbyte(input logic [7:0] tx, output logic [7:0] rx, output logic en);
    xbits(tx, 8, rx, en);
  endtask

  task automatic startCs(input bit mode3);
    sclk = mode3; waitc(H); csN = 1'b0; waitc(H);
  endtask

  task automatic endCs();
    waitc(H); csN = 1'b1; waitc(2); sclk = 1'b0; waitc(2 * H);
  endtask

  task automatic expReq(input string tag, input int idx, input logic [2:0] k,
                        input logic [23:0] a, input logic [7:0] d, input bit useA, input bit useD);
    chk({tag, " kind"}, 32'(logKind[idx]), 32'(k));
    if (useA) chk({tag, " addr"}, 32'(logAddr[idx]), 32'(a));
    if (useD) chk({tag, " data"}, 32'(logData[idx]), 32'(d));
  endtask

  task automatic t_reset();
    chk("R1 soEn after reset", 32'(soEn), 0);
    chk("R1 no request after reset", reqCnt, 0);
  endtask

  task automatic t_rdsr();
    logic [7:0] r; logic e;
    statusIn = 8'h5A;
    startCs(0);
    xbyte(8'h05, r, e);
    chk("R1 soEn low during opcode", 32'(e), 0);
    xbyte(8'h00, r, e);
    chk("R2 status byte 1", 32'(r), 32'h5A);
    chk("R1 soEn during output", 32'(e), 1);
    statusIn = 8'hC3;
    xbyte(8'h00, r, e);
    chk("R2 status byte 2 held", 32'(r), 32'h5A);
    xbyte(8'h00, r, e);
    chk("R2 status byte 3 refreshed", 32'(r), 32'hC3);
    endCs();
    chk("R1 soEn after deselect", 32'(soEn), 0);
  endtask

  task automatic t_rdid();
    logic [7:0] r; logic e;
    startCs(1);
    xbyte(8'h9F, r, e);
    xbyte(8'h00, r, e); chk("R3 R14 id byte 0", 32'(r), 32'(MFR));
    xbyte(8'h00, r, e); chk("R3 id byte 1", 32'(r), 32'(DHI));
    xbyte(8'h00, r, e); chk("R3 id byte 2", 32'(r), 32'(DLO));
    xbyte(8'h00, r, e); chk("R3 id repeat", 32'(r), 32'(MFR));
    endCs();
  endtask

  task automatic t_rems();
    logic [7:0] r; logic e;
    startCs(0);
    xbyte(8'h90, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e);
    xbyte(8'h00, r, e); chk("R4 sel0 first", 32'(r), 32'(MFR));
    xbyte(8'h00, r, e); chk("R4 sel0 second", 32'(r), 32'(ELEC));
    xbyte(8'h00, r, e); chk("R4 sel0 third", 32'(r), 32'(MFR));
    endCs();
    startCs(0);
    xbyte(8'h90, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e); xbyte(8'h01, r, e);
    xbyte(8'h00, r, e); chk("R4 sel1 first", 32'(r), 32'(ELEC));
    xbyte(8'h00, r, e); chk("R4 sel1 second", 32'(r), 32'(MFR));
    endCs();
  endtask

  task automatic t_read();
    logic [7:0] r; logic e;
    startCs(0);
    xbyte(8'h03, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e); xbyte(8'hFE, r, e);
    xbyte(8'h00, r, e); chk("R5 read FE", 32'(r), 32'(memExp(8'hFE)));
    xbyte(8'h00, r, e); chk("R5 read FF", 32'(r), 32'(memExp(8'hFF)));
    xbyte(8'h00, r, e); chk("R5 read wraps to 00", 32'(r), 32'(memExp(0)));
    endCs();
    startCs(1);
    xbyte(8'h03, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e); xbyte(8'h40, r, e);
    xbyte(8'h00, r, e); chk("R5 R14 mode3 read 40", 32'(r), 32'(memExp(8'h40)));
    xbyte(8'h00, r, e); chk("R5 R14 mode3 read 41", 32'(r), 32'(memExp(8'h41)));
    endCs();
  endtask

  task automatic t_fast();
    logic [7:0] r; logic e;
    startCs(0);
    xbyte(8'h0B, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e); xbyte(8'h10, r, e);
    xbyte(8'h00, r, e); chk("R6 dummy byte not driven", 32'(e), 0);
    xbyte(8'h00, r, e); chk("R6 fast 10", 32'(r), 32'(memExp(8'h10)));
    xbyte(8'h00, r, e); chk("R6 fast 11", 32'(r), 32'(memExp(8'h11)));
    endCs();
  endtask

  task automatic frame1(input logic [7:0] b);
    logic [7:0] r; logic e;
    startCs(0); xbyte(b, r, e); endCs();
  endtask

  task automatic t_single();
    int b = reqCnt;
    frame1(8'h06); frame1(8'h04); frame1(8'hC7); frame1(8'h60);
    chk("R8 four requests", reqCnt - b, 4);
    expReq("R8 WREN", b,     3'd1, 0, 0, 0, 0);
    expReq("R8 WRDI", b + 1, 3'd2, 0, 0, 0, 0);
    expReq("R8 CE C7", b + 2, 3'd6, 0, 0, 0, 0);
    expReq("R8 CE 60", b + 3, 3'd6, 0, 0, 0, 0);
  endtask

  task automatic t_partial();
    logic [7:0] r; logic e;
    int b = reqCnt;
    startCs(0); xbyte(8'h06, r, e); xbits(8'h80, 1, r, e); endCs();
    startCs(0); xbits(8'h06, 7, r, e); endCs();
    startCs(0); xbyte(8'hD8, r, e); xbyte(8'h01, r, e); xbyte(8'h02, r, e); endCs();
    startCs(0); xbyte(8'h06, r, e); xbyte(8'h06, r, e); endCs();
    chk("R11 no request for misframed commands", reqCnt - b, 0);
  endtask

  task automatic t_se();
    logic [7:0] r; logic e;
    int b = reqCnt;
    startCs(0);
    xbyte(8'hD8, r, e); xbyte(8'h2A, r, e); xbyte(8'h12, r, e); xbyte(8'h34, r, e);
    endCs();
    startCs(1);
    xbyte(8'h20, r, e); xbyte(8'h3F, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e);
    endCs();
    chk("R9 two erase requests", reqCnt - b, 2);
    expReq("R9 SE D8", b,     3'd5, 24'h2A1234, 0, 1, 0);
    expReq("R9 SE 20", b + 1, 3'd5, 24'h3F0000, 0, 1, 0);
  endtask

  task automatic t_pp();
    logic [7:0] r; logic e;
    int b = reqCnt;
    startCs(0);
    xbyte(8'h02, r, e); xbyte(8'h00, r, e); xbyte(8'h12, r, e); xbyte(8'hFE, r, e);
    xbyte(8'h11, r, e); xbyte(8'h22, r, e); xbyte(8'h33, r, e);
    endCs();
    chk("R7 three program requests", reqCnt - b, 3);
    expReq("R7 pp 0", b,     3'd4, 24'h0012FE, 8'h11, 1, 1);
    expReq("R7 pp 1", b + 1, 3'd4, 24'h0012FF, 8'h22, 1, 1);
    expReq("R7 pp page wrap", b + 2, 3'd4, 24'h001200, 8'h33, 1, 1);
  endtask

  task automatic t_wrsr();
    logic [7:0] r; logic e;
    int b = reqCnt;
    startCs(0); xbyte(8'h01, r, e); xbyte(8'h9C, r, e); endCs();
    chk("R10 one status write", reqCnt - b, 1);
    expReq("R10 WRSR", b, 3'd3, 0, 8'h9C, 0, 1);
  endtask

  task automatic t_dp();
    logic [7:0] r; logic e;
    int b = reqCnt;
    frame1(8'hB9);
    chk("R8 power down request", reqCnt - b, 1);
    expReq("R8 DP", b, 3'd7, 0, 0, 0, 0);
    statusIn = 8'h77;
    startCs(0); xbyte(8'h05, r, e); xbyte(8'h00, r, e);
    chk("R12 status read ignored in power down", 32'(e), 0);
    endCs();
    frame1(8'h06);
    chk("R12 WREN ignored in power down", reqCnt - b, 1);
    startCs(0);
    xbyte(8'hAB, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e); xbyte(8'h00, r, e);
    xbyte(8'h00, r, e); chk("R13 electronic id", 32'(r), 32'(ELEC));
    xbyte(8'h00, r, e); chk("R13 electronic id repeat", 32'(r), 32'(ELEC));
    endCs();
    startCs(0); xbyte(8'h05, r, e); xbyte(8'h00, r, e);
    chk("R12 status read after wake", 32'(r), 32'h77);
    endCs();
  endtask

  initial begin
    waitc(4); rstN = 1'b1; waitc(4);
    t_reset();
    t_rdsr();
    t_rdid();
    t_rems();
    t_read();
    t_fast();
    t_single();
    t_partial();
    t_se();
    t_pp();
    t_wrsr();
    t_dp();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChk++; nBad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
      $finish;
    end
  end
endmodule